// File: doc/BRIEF.md
# External interrupt pin controller

This block takes up to eight asynchronous interrupt pins from outside the chip. For each pin it produces a latched, maskable request. Every pin passes through a two-stage synchroniser. A detector then fires on a falling edge, a rising edge, either edge, a low level or a high level, chosen per pin by a packed sense field. A detection sets a pending flag. The flag stays set until software clears it, and it is set again on every cycle while a level-sensitive pin stays at its active level.

Software uses a small register port with one write strobe, a 3-bit address and a combinational read. Through it, software programs the sense fields and the 4-bit priority fields, reads and clears the pending flags, and masks or unmasks pins. Masking goes through a pair of write-only set and clear registers. A zero priority field blocks a pin in the same way as its mask bit. A mode bit in the control register enables the per-pin request outputs. The combined request output is always live.

The register addresses are: control 0, sense 1, priority 2, pending 3, mask-set 4, mask-clear 5.

Top module: `irqpin_ctl`

## Requirements
- R1: The sense register (address 1) is 32 bits wide. Pin n's field of SENSE_W bits (2 or 4) occupies bits [32-(n+1)*SENSE_W +: SENSE_W], so pin 0 is at the top. A write replaces all fields, reads return the stored fields, and bits outside any field read 0.
- R2: The sense codes are 0 falling edge, 1 rising edge, 2 low level, 3 high level and 4 either edge; code 4 exists only when SENSE_W is 4. Every other code detects nothing.
- R3: A pin change made before clock edge k sets its pending flag at edge k+2, through two synchronising flops. A pending flag is only ever set by a detection event.
- R4: The pending register (address 3) holds pin n's flag at bit SRC_W-1-n, and its other bits read 0. A write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. A detection in the same cycle wins over the clear. An edge flag holds until it is cleared.
- R5: Writing 1 to pin n's bit (SRC_W-1-n) of the mask-set register (address 4) masks the pin. Writing 1 to the same bit of the mask-clear register (address 5) unmasks it. A written 0 changes nothing, and both registers read as 0.
- R6: The priority register (address 2) holds a 4-bit field per pin at bits [32-(n+1)*4 +: 4] and reads back what was written. A zero field blocks the pin's request; any nonzero value lets it through.
- R7: The pin n request is asserted exactly when the pin is pending, unmasked, has a nonzero priority field and the mode bit is set. The combined request is asserted when any pin is pending, unmasked and has a nonzero priority field, whatever the mode bit.
- R8: Control register (address 0) bit 23 is the individual-pin mode bit, and all other control bits read 0. While the mode bit is clear, every per-pin request output is low.
- R9: After reset, all pins are masked, and the priority fields, sense fields, pending flags and mode bit are all zero.
- R10: In a level mode, a pending flag cannot be cleared while the pin stays at its active level. After the pin leaves that level, the flag holds until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Asynchronous interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pin_req_o | output | NPINS | Per-pin qualified requests |
| any_req_o | output | 1 | Combined request |

## Verification
The bench builds the block with NPINS=8, SENSE_W=4 and SRC_W=8. With these values the sense and priority registers are filled to all 32 bits, so any misplaced field shows up on readback. They also make the either-edge code 4 and the reserved codes 5 to 15 reachable. Using eight pins in an 8-bit pending register puts pin 0 on bit 7, which exposes any reversal of the bit order between the pending, mask-set and mask-clear registers.

// File: rtl/irqpin_pkg.sv
package irqpin_pkg;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_SENSE = 3'd1;
  localparam logic [2:0] A_PRIO  = 3'd2;
  localparam logic [2:0] A_PEND  = 3'd3;
  localparam logic [2:0] A_MSET  = 3'd4;
  localparam logic [2:0] A_MCLR  = 3'd5;

  localparam int PRIO_W   = 4;
  localparam int MODE_POS = 23;

  typedef enum logic [3:0] {
    SNS_FALL = 4'd0,
    SNS_RISE = 4'd1,
    SNS_LOW  = 4'd2,
    SNS_HIGH = 4'd3,
    SNS_BOTH = 4'd4
  } sense_e;

  // lowest bit of a pin's field, fields packed downward from bit 31
  function automatic int field_lsb(input int pin, input int w);
    return 32 - (pin + 1) * w;
  endfunction

  // bit of a pin in the pending / mask registers, pin 0 on top
  function automatic int src_pos(input int pin, input int regw);
    return regw - 1 - pin;
  endfunction

  // all bits covered by the fields of npins pins
  function automatic logic [31:0] field_cover(input int npins, input int w);
    logic [31:0] m;
    m = '0;
    for (int p = 0; p < npins; p++)
      for (int b = 0; b < w; b++)
        m[field_lsb(p, w) + b] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irqpin_sync.sv
module irqpin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_s,
  output logic pin_d
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_async};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign pin_s = chain_q[STAGES-1];
  assign pin_d = last_q;
endmodule

// File: rtl/irqpin_detect.sv
module irqpin_detect
  import irqpin_pkg::*;
#(
  parameter int SENSE_W = 4
) (
  input  logic               pin_s,
  input  logic               pin_d,
  input  logic [SENSE_W-1:0] code,
  output logic               evt
);
  logic [3:0] code4;
  logic       rise, fall;

  assign code4 = 4'(code);
  assign rise  = pin_s & ~pin_d;
  assign fall  = ~pin_s & pin_d;

  always_comb begin
    unique case (code4)
      SNS_FALL: evt = fall;
      SNS_RISE: evt = rise;
      SNS_LOW:  evt = ~pin_s;
      SNS_HIGH: evt = pin_s;
      SNS_BOTH: evt = rise | fall;
      default:  evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/irqpin_regs.sv
module irqpin_regs
  import irqpin_pkg::*;
#(
  parameter int NPINS   = 8,
  parameter int SENSE_W = 4,
  parameter int SRC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [2:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [NPINS-1:0]         det_evt,
  output logic [NPINS*SENSE_W-1:0] sense_codes,
  output logic [NPINS-1:0]         prio_ok,
  output logic [NPINS-1:0]         pend_q,
  output logic [NPINS-1:0]         mask_q,
  output logic                     mode_q,
  output logic [NPINS-1:0]         mset_hit,
  output logic [NPINS-1:0]         mclr_hit,
  output logic [NPINS-1:0]         src_clr
);
  localparam logic [31:0] SENSE_COVER = field_cover(NPINS, SENSE_W);
  localparam logic [31:0] PRIO_COVER  = field_cover(NPINS, PRIO_W);

  logic [31:0] sense_q, prio_q;
  logic [31:0] pend_view;
  logic        wr_ctrl, wr_sense, wr_prio, wr_pend, wr_mset, wr_mclr;

  assign wr_ctrl  = reg_we && reg_addr == A_CTRL;
  assign wr_sense = reg_we && reg_addr == A_SENSE;
  assign wr_prio  = reg_we && reg_addr == A_PRIO;
  assign wr_pend  = reg_we && reg_addr == A_PEND;
  assign wr_mset  = reg_we && reg_addr == A_MSET;
  assign wr_mclr  = reg_we && reg_addr == A_MCLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      prio_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      if (wr_sense) sense_q <= reg_wdata & SENSE_COVER;
      if (wr_prio)  prio_q  <= reg_wdata & PRIO_COVER;
      if (wr_ctrl)  mode_q  <= reg_wdata[MODE_POS];
    end
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    localparam int SLSB = field_lsb(n, SENSE_W);
    localparam int PLSB = field_lsb(n, PRIO_W);
    localparam int SP   = src_pos(n, SRC_W);

    assign sense_codes[n*SENSE_W +: SENSE_W] = sense_q[SLSB +: SENSE_W];
    assign prio_ok[n]  = prio_q[PLSB +: PRIO_W] != '0;
    assign mset_hit[n] = wr_mset && reg_wdata[SP];
    assign mclr_hit[n] = wr_mclr && reg_wdata[SP];
    assign src_clr[n]  = wr_pend && !reg_wdata[SP];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[n] <= 1'b0;
        mask_q[n] <= 1'b1;
      end else begin
        if (det_evt[n])      pend_q[n] <= 1'b1;
        else if (src_clr[n]) pend_q[n] <= 1'b0;
        if (mset_hit[n])      mask_q[n] <= 1'b1;
        else if (mclr_hit[n]) mask_q[n] <= 1'b0;
      end
    end
  end

  always_comb begin
    pend_view = '0;
    for (int n = 0; n < NPINS; n++)
      pend_view[src_pos(n, SRC_W)] = pend_q[n];
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL:  reg_rdata[MODE_POS] = mode_q;
      A_SENSE: reg_rdata = sense_q;
      A_PRIO:  reg_rdata = prio_q;
      A_PEND:  reg_rdata = pend_view;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqpin_ctl.sv
module irqpin_ctl
  import irqpin_pkg::*;
#(
  parameter int NPINS   = 8,
  parameter int SENSE_W = 4,
  parameter int SRC_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [NPINS-1:0] pin_req_o,
  output logic             any_req_o
);
  logic [NPINS-1:0]         pin_s, pin_d, det_evt;
  logic [NPINS*SENSE_W-1:0] sense_codes;
  logic [NPINS-1:0]         prio_ok, pend_q, mask_q;
  logic [NPINS-1:0]         mset_hit, mclr_hit, src_clr;
  logic [NPINS-1:0]         qual;
  logic                     mode_q;

  for (genvar n = 0; n < NPINS; n++) begin : g_front
    irqpin_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_i[n]),
      .pin_s(pin_s[n]), .pin_d(pin_d[n])
    );
    irqpin_detect #(.SENSE_W(SENSE_W)) u_det (
      .pin_s(pin_s[n]), .pin_d(pin_d[n]),
      .code(sense_codes[n*SENSE_W +: SENSE_W]), .evt(det_evt[n])
    );
  end

  irqpin_regs #(.NPINS(NPINS), .SENSE_W(SENSE_W), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .det_evt(det_evt),
    .sense_codes(sense_codes), .prio_ok(prio_ok),
    .pend_q(pend_q), .mask_q(mask_q), .mode_q(mode_q),
    .mset_hit(mset_hit), .mclr_hit(mclr_hit), .src_clr(src_clr)
  );

  assign qual      = pend_q & ~mask_q & prio_ok;
  assign pin_req_o = mode_q ? qual : '0;
  assign any_req_o = |qual;
endmodule

// File: rtl/irqpin_chk.sv
module irqpin_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] det_evt,
  input logic [NPINS-1:0] pend_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] mset_hit,
  input logic [NPINS-1:0] mclr_hit,
  input logic [NPINS-1:0] src_clr,
  input logic [NPINS-1:0] pin_req_o,
  input logic             any_req_o,
  input logic             mode_q
);
  // R3: a flag only rises after a detection event
  p_set_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(det_evt)) == '0);

  // R4: a flag only falls after a clearing write with no detection
  p_clear_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend_q & $past(pend_q)) & ~($past(src_clr) & ~$past(det_evt))) == '0);

  // R5: mask bits change only on a set or clear write with a 1
  p_mask_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q ^ $past(mask_q)) & ~($past(mset_hit) | $past(mclr_hit))) == '0);

  // R7: a pin request needs a pending, unmasked pin
  p_req_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_req_o & ~(pend_q & ~mask_q)) == '0);

  // R7: any pin request implies the combined request
  p_any_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_req_o != '0) |-> any_req_o);

  // R8: mode bit clear silences the per-pin outputs
  p_mode_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (pin_req_o == '0));

  // R9: leaving reset with everything masked and nothing pending
  p_reset_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((&mask_q) && pend_q == '0 && !mode_q));
endmodule

bind irqpin_ctl irqpin_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .det_evt(det_evt), .pend_q(pend_q),
  .mask_q(mask_q), .mset_hit(mset_hit), .mclr_hit(mclr_hit),
  .src_clr(src_clr), .pin_req_o(pin_req_o), .any_req_o(any_req_o),
  .mode_q(mode_q)
);

// File: tb/sim_irqpin_ctl.sv
`timescale 1ns/1ps
module sim_irqpin_ctl;
  localparam int NPINS = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pin_i = 8'h04;
  logic             reg_we = 1'b0;
  logic [2:0]       reg_addr = 3'd0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [NPINS-1:0] pin_req_o;
  logic             any_req_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  irqpin_ctl #(.NPINS(8), .SENSE_W(4), .SRC_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_req_o(pin_req_o), .any_req_o(any_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drive_pins(input logic [NPINS-1:0] v);
    @(negedge clk);
    pin_i = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); check("R9 ctrl after reset", d, 32'h0);
    rd(3'd1, d); check("R9 sense after reset", d, 32'h0);
    rd(3'd2, d); check("R9 prio after reset", d, 32'h0);
    rd(3'd3, d); check("R9 pending after reset", d, 32'h0);
    check("R9 outputs after reset", {23'h0, any_req_o, pin_req_o}, 32'h0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    wr(3'd1, 32'h1234_5678); rd(3'd1, d); check("R1 sense readback", d, 32'h1234_5678);
    wr(3'd2, 32'hA5A5_0F0F); rd(3'd2, d); check("R6 prio readback", d, 32'hA5A5_0F0F);
    wr(3'd2, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); check("R8 ctrl only bit 23", d, 32'h0080_0000);
    wr(3'd0, 32'h0);
    rd(3'd4, d); check("R5 mask-set reads 0", d, 32'h0);
    rd(3'd5, d); check("R5 mask-clear reads 0", d, 32'h0);
  endtask

  task automatic t_detect;
    logic [31:0] d;
    // pin0 fall, pin1 rise, pin2 low, pin3 high, pin4 both, pin5 reserved 7, pin6/7 rise
    wr(3'd1, 32'h0123_4711);
    wr(3'd3, 32'h0); rd(3'd3, d); check("R4 all-zero write clears", d, 32'h0);
    // R3 latency: change before edge k, flag seen after edge k+2
    @(negedge clk); pin_i = 8'h06;
    @(negedge clk); @(negedge clk); #1; reg_addr = 3'd3; #1;
    check("R3 not yet after two edges", reg_rdata, 32'h0);
    @(negedge clk); #1 check("R3 set after third edge", reg_rdata, 32'h40);
    drive_pins(8'h07); rd(3'd3, d); check("R2 rising ignored in falling mode", d, 32'h40);
    drive_pins(8'h06); rd(3'd3, d); check("R2 falling edge pin0", d, 32'hC0);
    wr(3'd3, 32'h80); rd(3'd3, d); check("R4 keep ones clear zeros", d, 32'h80);
    repeat (3) @(negedge clk); rd(3'd3, d); check("R4 edge flag holds", d, 32'h80);
    wr(3'd3, 32'h0);
    drive_pins(8'h04); rd(3'd3, d); check("R2 falling ignored in rising mode", d, 32'h0);
    drive_pins(8'h14); rd(3'd3, d); check("R2 both-edge rise", d, 32'h08);
    wr(3'd3, 32'h0);
    drive_pins(8'h04); rd(3'd3, d); check("R2 both-edge fall", d, 32'h08);
    wr(3'd3, 32'h0);
    drive_pins(8'h24); drive_pins(8'h04); rd(3'd3, d); check("R2 reserved code silent", d, 32'h0);
    drive_pins(8'h0C); rd(3'd3, d); check("R2 high level pin3", d, 32'h10);
    wr(3'd3, 32'h0); rd(3'd3, d); check("R10 level flag survives clear", d, 32'h10);
    drive_pins(8'h04); rd(3'd3, d); check("R10 level flag holds after release", d, 32'h10);
    wr(3'd3, 32'h0); rd(3'd3, d); check("R10 cleared after release", d, 32'h0);
    drive_pins(8'h00); rd(3'd3, d); check("R2 low level pin2", d, 32'h20);
    drive_pins(8'h04); wr(3'd3, 32'h0); rd(3'd3, d); check("R4 cleared", d, 32'h0);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    wr(3'd0, 32'h0080_0000);
    drive_pins(8'h44); rd(3'd3, d); check("R4 pin6 at bit 1", d, 32'h02);
    check("R9 masked and prio zero", {23'h0, any_req_o, pin_req_o}, 32'h0);
    wr(3'd2, 32'h0000_00F0);
    check("R9 still masked from reset", {23'h0, any_req_o, pin_req_o}, 32'h0);
    wr(3'd5, 32'h02); check("R7 unmasked request", {23'h0, any_req_o, pin_req_o}, 32'h140);
    wr(3'd4, 32'h00); check("R5 zero write to mask-set", {23'h0, any_req_o, pin_req_o}, 32'h140);
    wr(3'd5, 32'hFD); check("R5 other clears leave pin6", {23'h0, any_req_o, pin_req_o}, 32'h140);
    wr(3'd4, 32'h02); check("R5 mask-set masks", {23'h0, any_req_o, pin_req_o}, 32'h0);
    wr(3'd5, 32'h02); check("R5 mask-clear unmasks", {23'h0, any_req_o, pin_req_o}, 32'h140);
    wr(3'd2, 32'h0); check("R6 zero prio blocks", {23'h0, any_req_o, pin_req_o}, 32'h0);
    wr(3'd2, 32'h10); check("R6 prio 1 passes", {23'h0, any_req_o, pin_req_o}, 32'h140);
    wr(3'd2, 32'h0F); check("R6 neighbour field only", {23'h0, any_req_o, pin_req_o}, 32'h0);
    wr(3'd2, 32'hF0);
    wr(3'd0, 32'h0); check("R8 mode clear silences pins", {23'h0, any_req_o, pin_req_o}, 32'h100);
    wr(3'd3, 32'hFF); check("R4 all-ones write keeps", {23'h0, any_req_o, pin_req_o}, 32'h100);
    wr(3'd3, 32'h0); check("R7 cleared drops combined", {23'h0, any_req_o, pin_req_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_fields();
    t_detect();
    t_gate();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule